// File: doc/BRIEF.md
# Two-Channel Interval Timer

This block counts down a 16-bit interval on two independent channels, numbered 0 and 2, at the rate of a single-cycle tick enable. The tick enable is meant to run at 1,193,180 Hz, so a programmed count of N gives an interval of N ticks. A host writes bytes into the block through one write port. A control byte picks a channel and a mode. Each channel is then given its count as two data bytes, low byte first. A channel starts counting only when its second byte arrives.

In mode 0 a channel fires once. It raises a flag in a status byte and halts. In every other mode it reloads its count and fires again with the same period. Each channel also gives a one-cycle terminal-count pulse every time it expires. The status byte reports channel 2 only. A control byte that asks for an unsupported access order or an unsupported channel is refused and raises an error pulse.

The write port uses a valid/ready handshake. `wr_ready` is always high, so the block never applies back-pressure. A byte is taken on every rising edge where `wr_valid` is high.

Top module: `dual_interval_timer`

## Requirements
- R1: A control write (`wr_addr` = 2) is legal when bits 5:4 are `11`. Bits 7:6 select the channel: `00` selects channel 0 and `10` selects channel 2. Bits 3:1 become that channel's mode, and that mode is applied at the channel's next expiry. A legal write gives no error pulse.
- R2: A control write is illegal when bits 5:4 are not `11`, or when bits 7:6 are `01` or `11`. An illegal write makes `cfg_err` high for one cycle, the cycle after the write. It changes no mode.
- R3: The two data targets, `wr_addr` 0 (channel 0) and 1 (channel 2), share one byte-order flag and one staging byte. The first data write stores the low byte. The second data write supplies the high byte and starts the channel addressed by that second write, with count {high, low}. Control writes leave the flag and the staging byte untouched.
- R4: A first data byte on its own does not start, restart or alter any channel.
- R5: Starting a channel clears that channel's expiry flag, and the cleared flag shows in the following cycle.
- R6: After a start with count N, the channel expires on exactly the Nth rising edge on which `tick_en` is high. Edges with `tick_en` low do not count.
- R7: In mode 0 the channel halts at expiry and sets status bit 5, so `status_o` reads 0x20. It does not fire again until it is started again.
- R8: In any nonzero mode the channel reloads at expiry and fires again every N ticks.
- R9: A count of 0 gives an interval of 65536 ticks.
- R10: `status_o` reflects channel 2 only. An expiry of channel 0 never changes it, and all bits other than bit 5 read 0.
- R11: `tc_o[0]` (channel 0) and `tc_o[1]` (channel 2) are high for exactly the one cycle after the expiring tick edge.
- R12: `wr_ready` is always 1. A write to `wr_addr` 3 has no effect and gives no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable, one pulse per timer tick |
| wr_valid | input | 1 | Host write valid |
| wr_ready | output | 1 | Host write ready (always 1) |
| wr_addr | input | 2 | Write target: 0 = channel 0 data, 1 = channel 2 data, 2 = control, 3 = none |
| wr_data | input | 8 | Write byte |
| status_o | output | 8 | Channel 2 status byte; bit 5 = one-shot expired |
| cfg_err | output | 1 | One-cycle pulse after an illegal control byte |
| tc_o | output | 2 | Terminal-count pulses: bit 0 = channel 0, bit 1 = channel 2 |

## Verification
The bench builds the block with its default byte width of 8, which gives 16-bit counts. It drives `tick_en` on every clock while a channel runs. Because of that, the full 65536-tick interval for a count of zero fits in a short run, along with exact expiry-edge counts for small intervals and periods of 1 and 4. Since the byte-order flag is shared, the bench can split one count across the two data targets and check which channel starts. It can also slip control writes and writes to the empty target between the two bytes.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int NUM_CH = 2;

  typedef logic [2:0] mode_t;

  typedef enum logic [1:0] {
    TGT_DATA0 = 2'd0,
    TGT_DATA2 = 2'd1,
    TGT_CTRL  = 2'd2,
    TGT_NONE  = 2'd3
  } tgt_e;

  typedef struct packed {
    logic  valid;
    logic  ch_idx;
    mode_t mode;
  } ctl_cmd_t;
endpackage

// File: rtl/ivt_ctrl_decode.sv
module ivt_ctrl_decode
  import ivt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_fire,
  input  logic [DATA_W-1:0] ctl_byte,
  output ctl_cmd_t          cmd,
  output logic              err_q
);
  logic [1:0] chan_sel;
  logic [1:0] access;
  logic       legal;

  assign chan_sel = ctl_byte[7:6];
  assign access   = ctl_byte[5:4];
  assign legal    = (access == 2'b11) && ((chan_sel == 2'b00) || (chan_sel == 2'b10));

  always_comb begin
    cmd.valid  = ctl_fire && legal;
    cmd.ch_idx = chan_sel[1];
    cmd.mode   = ctl_byte[3:1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= ctl_fire && !legal;
  end

  // R2: an error pulse only ever follows a control write
  a_r2_err_after_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(ctl_fire));
endmodule

// File: rtl/ivt_byte_stager.sv
module ivt_byte_stager
  import ivt_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_fire,
  input  logic              ch_idx_in,
  input  logic [DATA_W-1:0] byte_in,
  output logic [NUM_CH-1:0] start,
  output logic [CNT_W-1:0]  load_val
);
  logic              toggle_q;
  logic [DATA_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      toggle_q <= 1'b0;
      lo_q     <= '0;
    end else if (data_fire) begin
      if (!toggle_q) begin
        lo_q     <= byte_in;
        toggle_q <= 1'b1;
      end else begin
        toggle_q <= 1'b0;
      end
    end
  end

  assign load_val = {byte_in, lo_q};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_start
    assign start[c] = data_fire && toggle_q && (ch_idx_in == 1'(c));
  end

  // R3: every accepted data byte flips the shared byte-order flag
  a_r3_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    data_fire |=> (toggle_q != $past(toggle_q)));
  // R3: at most one channel starts per write
  a_r3_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start));
endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
  import ivt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  input  logic             mode_wr,
  input  mode_t            mode_in,
  output logic             tc_q,
  output logic             done_q
);
  mode_t            mode_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             oneshot;
  logic             at_end;

  assign oneshot = (mode_q == 3'd0);
  assign at_end  = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      reload_q <= '0;
      cnt_q    <= '0;
      run_q    <= 1'b0;
      done_q   <= 1'b0;
      tc_q     <= 1'b0;
    end else begin
      tc_q <= 1'b0;
      if (mode_wr) mode_q <= mode_in;
      if (start) begin
        reload_q <= load_val;
        cnt_q    <= load_val;
        run_q    <= 1'b1;
        done_q   <= 1'b0;
      end else if (run_q && tick_en) begin
        if (at_end) begin
          tc_q <= 1'b1;
          if (oneshot) begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
          end else begin
            cnt_q <= reload_q;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  // R11: a terminal-count pulse follows a counting tick
  a_r11_tc_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q |-> $past(tick_en && run_q));
  // R7: one-shot expiry halts the channel and flags it
  a_r7_oneshot_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_q && $past(mode_q == 3'd0)) |-> (!run_q && done_q));
  // R8: periodic expiry restores the programmed count
  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_q && run_q) |-> (cnt_q == reload_q));
  // R5: a start clears the flag and runs the channel
  a_r5_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done_q && run_q));
  // R6: an idle channel holds its count
  a_r6_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start) |=> $stable(cnt_q));
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import ivt_pkg::*;
#(
  parameter int                DATA_W      = 8,
  parameter int                STATUS_BIT  = 5,
  parameter logic [NUM_CH-1:0] STATUS_MASK = 2'b10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] status_o,
  output logic              cfg_err,
  output logic [NUM_CH-1:0] tc_o
);
  localparam int CNT_W = 2 * DATA_W;

  tgt_e              wr_tgt;
  logic              ctl_fire;
  logic              data_fire;
  ctl_cmd_t          cmd;
  logic [NUM_CH-1:0] start_v;
  logic [NUM_CH-1:0] done_v;
  logic [CNT_W-1:0]  load_val;

  assign wr_ready  = 1'b1;
  assign wr_tgt    = tgt_e'(wr_addr);
  assign ctl_fire  = wr_valid && (wr_tgt == TGT_CTRL);
  assign data_fire = wr_valid && ((wr_tgt == TGT_DATA0) || (wr_tgt == TGT_DATA2));

  ivt_ctrl_decode #(.DATA_W(DATA_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_fire (ctl_fire),
    .ctl_byte (wr_data),
    .cmd      (cmd),
    .err_q    (cfg_err)
  );

  ivt_byte_stager #(.DATA_W(DATA_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_fire (data_fire),
    .ch_idx_in (wr_tgt == TGT_DATA2),
    .byte_in   (wr_data),
    .start     (start_v),
    .load_val  (load_val)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ivt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .start    (start_v[g]),
      .load_val (load_val),
      .mode_wr  (cmd.valid && (cmd.ch_idx == 1'(g))),
      .mode_in  (cmd.mode),
      .tc_q     (tc_o[g]),
      .done_q   (done_v[g])
    );
  end

  always_comb begin
    status_o             = '0;
    status_o[STATUS_BIT] = |(done_v & STATUS_MASK);
  end

  // R12: writes to the empty target never raise an error
  a_r12_none_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_tgt == TGT_NONE) |=> !cfg_err);
  // R10: the status flag can only rise after a channel-2 pulse
  a_r10_status_from_ch2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[STATUS_BIT]) |-> tc_o[1]);
endmodule

// File: tb/sim_dual_interval_timer.sv
module sim_dual_interval_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [1:0] wr_addr = 2'd3;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] status_o;
  logic       cfg_err;
  logic [1:0] tc_o;

  int n_chk = 0;
  int n_bad = 0;
  logic last_err;

  always #2.5 clk = ~clk;

  dual_interval_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .status_o(status_o), .cfg_err(cfg_err), .tc_o(tc_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0; wr_addr = 2'd3;
    last_err = cfg_err;
  endtask

  task automatic run(input int n, input int ch, output int first, output int hits);
    first = 0; hits = 0;
    @(negedge clk);
    tick_en = 1'b1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (tc_o[ch]) begin
        hits++;
        if (first == 0) first = i;
      end
    end
    tick_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 ready", int'(wr_ready), 1);
    chk("R10 reset status", int'(status_o), 0);
    chk("R11 reset tc", int'(tc_o), 0);
    chk("R2 reset err", int'(cfg_err), 0);
  endtask

  task automatic t_illegal_and_oneshot();
    int f, h;
    wr(2'd2, 8'h90); chk("R2 access 01", int'(last_err), 1);
    wr(2'd2, 8'hF6); chk("R2 select 11", int'(last_err), 1);
    wr(2'd2, 8'h76); chk("R2 select 01", int'(last_err), 1);
    wr(2'd2, 8'hB0); chk("R1 legal ch2 mode0", int'(last_err), 0);
    wr(2'd2, 8'h94); chk("R2 illegal periodic", int'(last_err), 1);
    wr(2'd1, 8'h05); wr(2'd1, 8'h00);
    run(20, 1, f, h);
    chk("R6 expiry tick", f, 5);
    chk("R7 single fire (R2 mode unchanged)", h, 1);
    chk("R7 status 0x20", int'(status_o), 32'h20);
  endtask

  task automatic t_first_byte();
    int f, h;
    wr(2'd1, 8'h07);
    chk("R4 status kept", int'(status_o), 32'h20);
    run(10, 1, f, h);
    chk("R4 no restart", h, 0);
    wr(2'd1, 8'h00);
    chk("R5 start clears", int'(status_o), 0);
    run(10, 1, f, h);
    chk("R6 count 7", f, 7);
  endtask

  task automatic t_ch0_no_status();
    int f, h;
    wr(2'd2, 8'hB0);
    wr(2'd1, 8'h00); wr(2'd1, 8'h01);
    chk("R10 ch2 restarted", int'(status_o), 0);
    wr(2'd2, 8'h30); chk("R1 legal ch0", int'(last_err), 0);
    wr(2'd0, 8'h03); wr(2'd0, 8'h00);
    run(6, 0, f, h);
    chk("R7 ch0 one-shot", h, 1);
    chk("R10 ch0 leaves status", int'(status_o), 0);
  endtask

  task automatic t_periodic();
    int f, h;
    wr(2'd2, 8'h34); chk("R1 ch0 mode2", int'(last_err), 0);
    wr(2'd0, 8'h04); wr(2'd0, 8'h00);
    run(12, 0, f, h);
    chk("R8 first", f, 4);
    chk("R8 period 4", h, 3);
    @(negedge clk);
    chk("R11 tc low after", int'(tc_o[0]), 0);
    wr(2'd0, 8'h01); wr(2'd0, 8'h00);
    run(5, 0, f, h);
    chk("R11 period 1 pulses", h, 5);
  endtask

  task automatic t_shared_toggle();
    int f, h;
    wr(2'd2, 8'hB0);
    wr(2'd0, 8'h03); wr(2'd1, 8'h00);
    run(6, 1, f, h);
    chk("R3 split load", f, 3);
    wr(2'd1, 8'h02); wr(2'd2, 8'hB0); wr(2'd1, 8'h00);
    run(5, 1, f, h);
    chk("R3 ctl between bytes", f, 2);
    wr(2'd1, 8'h05); wr(2'd3, 8'hFF);
    chk("R12 none no err", int'(last_err), 0);
    wr(2'd1, 8'h00);
    run(8, 1, f, h);
    chk("R12 none ignored", f, 5);
  endtask

  task automatic t_tick_gate();
    int f, h, seen;
    seen = 0;
    wr(2'd1, 8'h04); wr(2'd1, 8'h00);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (tc_o[1]) seen++;
    end
    chk("R6 no tick no count", seen, 0);
    run(6, 1, f, h);
    chk("R6 gated count", f, 4);
  endtask

  task automatic t_count_zero();
    int f, h;
    wr(2'd1, 8'h00); wr(2'd1, 8'h00);
    run(65535, 1, f, h);
    chk("R9 not before 65536", h, 0);
    run(1, 1, f, h);
    chk("R9 at 65536", h, 1);
    chk("R9 status", int'(status_o), 32'h20);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_illegal_and_oneshot();
    t_first_byte();
    t_ch0_no_status();
    t_periodic();
    t_shared_toggle();
    t_tick_gate();
    t_count_zero();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule